// File: doc/BRIEF.md
# Switched I/O Port Bank Selector

This block is one peripheral on an 8-bit I/O bus that shares a sixteen-port window with other peripherals. The lowest port of the window (default 0x40) holds a bank identifier. Every peripheral on the bus loads this identifier on each write to that port. The other fifteen ports of the window connect only to the peripheral whose fixed identifier equals the stored value. When software reads the identifier port, the selected peripheral returns the bitwise inverse of the identifier. Software uses this to test whether a peripheral is present: it writes an identifier, reads the port back, and compares the result with the inverse of what it wrote.

The peripheral modelled here has one control register at window offset 1. That register holds a writable CPU-speed select bit and two read-only status inputs. The other switched ports read as all ones. As an option, the switched ports can also require a fixed upper address byte. This gives each identifier a much larger address space. Reads are combinational, and the block drives the bus only through `drive_o`. Writes take effect on the rising clock edge.

Top module: `sio_bank_sel`

## Requirements
- R1: After reset the stored identifier is 0, so the block is not selected and does not drive. `speed_slow_o` is 1.
- R2: Every write to the identifier port (low address byte = BASE) loads `wdata_i` into the identifier register, whatever value it held before.
- R3: A read of the identifier port while the stored identifier equals DEV_ID asserts `drive_o`, with `rdata_o` = ~DEV_ID.
- R4: While the stored identifier differs from DEV_ID, `drive_o` stays 0 for reads of the identifier port and of the switched ports BASE+1 to BASE+15.
- R5: A write to BASE+1 while selected loads `wdata_i[0]` into the speed bit, which appears on `speed_slow_o` (0 = fast, 1 = normal) from the next cycle.
- R6: Writes to the switched ports while another identifier is selected leave the speed bit unchanged.
- R7: A read of BASE+1 while selected returns bit 0 = speed bit, bit 2 = `fast_avail_ni`, bit 7 = `sw_off_i`, and ones in bits 1, 3, 4, 5 and 6.
- R8: Bits 2 and 7 of BASE+1 follow only their input pins. Writing to them has no effect.
- R9: A read of BASE+2 to BASE+15 while selected drives 0xFF.
- R10: With WIDE_DECODE = 1, the switched ports respond only when address bits [15:8] equal HI_TAG. The identifier port is always decoded on the low byte alone.
- R11: Whenever `drive_o` is 0, `rdata_o` is 0x00. `drive_o` is never 1 without `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| fast_avail_ni | input | 1 | Fast mode available, active low |
| sw_off_i | input | 1 | Switch status, 0 = on |
| rdata_o | output | 8 | Read data |
| drive_o | output | 1 | Read data valid / bus drive enable |
| speed_slow_o | output | 1 | CPU speed select, 1 = normal |

## Verification
The assertions check the following on every cycle: the identifier loads on writes, the inverted readback, the read-only status bits, the all-ones spare ports, a quiet bus whenever the block does not drive, and a stable speed bit across writes made while the block is deselected. The bench scenarios cover the rest. They show presence detection after an identifier change, writes that are ignored and later read back once the block is selected, behaviour from reset, and the upper-byte qualification of the wide variant against the narrow one.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned DATA_W = 8;
  typedef enum logic [1:0] {SEL_NONE, SEL_ID, SEL_CTRL, SEL_SPARE} sio_sel_e;
endpackage

// File: rtl/sio_decode.sv
module sio_decode
  import sio_pkg::*;
#(
  parameter int unsigned    ADDR_W      = 16,
  parameter logic [7:0]     BASE        = 8'h40,
  parameter logic [3:0]     CTRL_OFS    = 4'h1,
  parameter bit             WIDE_DECODE = 1'b0,
  parameter logic [ADDR_W-9:0] HI_TAG   = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sio_sel_e          sel_o
);
  logic [7:0] port;
  logic       hi_ok;
  assign port = addr_i[7:0];

  generate
    if (WIDE_DECODE) begin : g_wide
      assign hi_ok = (addr_i[ADDR_W-1:8] == HI_TAG);
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:8];
      assign hi_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    sel_o = SEL_NONE;
    if (port == BASE) sel_o = SEL_ID;
    else if (port[7:4] == BASE[7:4] && hi_ok)
      sel_o = (port[3:0] == CTRL_OFS) ? SEL_CTRL : SEL_SPARE;
  end
endmodule

// File: rtl/sio_id_reg.sv
module sio_id_reg
  import sio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg
  import sio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              fast_avail_ni,
  input  logic              sw_off_i,
  output logic              speed_o,
  output logic [DATA_W-1:0] view_o
);
  logic unused_d;
  assign unused_d = ^d_i[DATA_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   speed_o <= 1'b1;
    else if (we_i) speed_o <= d_i[0];
  end

  // read-only bits come straight from pins; spare bits read as one
  assign view_o = {sw_off_i, 4'b1111, fast_avail_ni, 1'b1, speed_o};
endmodule

// File: rtl/sio_bank_sel.sv
module sio_bank_sel
  import sio_pkg::*;
#(
  parameter logic [7:0]        DEV_ID      = 8'd8,
  parameter logic [7:0]        BASE        = 8'h40,
  parameter bit                WIDE_DECODE = 1'b0,
  parameter logic [7:0]        HI_TAG      = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        fast_avail_ni,
  input  logic        sw_off_i,
  output logic [7:0]  rdata_o,
  output logic        drive_o,
  output logic        speed_slow_o
);
  sio_sel_e          sel;
  logic [DATA_W-1:0] id_q;
  logic [DATA_W-1:0] ctrl_view;
  logic              hit;

  sio_decode #(
    .ADDR_W(16), .BASE(BASE), .CTRL_OFS(4'h1),
    .WIDE_DECODE(WIDE_DECODE), .HI_TAG(HI_TAG)
  ) i_decode (
    .addr_i(addr_i), .sel_o(sel)
  );

  // every device tracks the shared identifier
  sio_id_reg i_id (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_i && sel == SEL_ID),
    .d_i(wdata_i), .q_o(id_q)
  );

  assign hit = (id_q == DEV_ID);

  sio_ctrl_reg i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_i && hit && sel == SEL_CTRL),
    .d_i(wdata_i),
    .fast_avail_ni(fast_avail_ni), .sw_off_i(sw_off_i),
    .speed_o(speed_slow_o), .view_o(ctrl_view)
  );

  always_comb begin
    drive_o = 1'b0;
    rdata_o = '0;
    if (rd_i && hit) begin
      unique case (sel)
        SEL_ID:    begin drive_o = 1'b1; rdata_o = ~id_q;     end
        SEL_CTRL:  begin drive_o = 1'b1; rdata_o = ctrl_view; end
        SEL_SPARE: begin drive_o = 1'b1; rdata_o = 8'hFF;     end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/sio_bank_sel_chk.sv
module sio_bank_sel_chk #(
  parameter logic [7:0] DEV_ID = 8'd8,
  parameter logic [7:0] BASE   = 8'h40
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic        fast_avail_ni,
  input logic        sw_off_i,
  input logic [7:0]  rdata_o,
  input logic        drive_o,
  input logic        speed_slow_o,
  input logic [7:0]  id_q
);
  logic [7:0] port;
  assign port = addr_i[7:0];

  a_r2_id_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && port == BASE) |=> id_q == $past(wdata_i));

  a_r3_inverted_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && port == BASE && id_q == DEV_ID) |-> (drive_o && rdata_o == ~DEV_ID));

  a_r4_silent_unsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_q != DEV_ID) |-> !drive_o);

  a_r6_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && id_q != DEV_ID) |=> $stable(speed_slow_o));

  a_r8_ro_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && port == BASE + 8'd1) |-> (rdata_o[7] == sw_off_i && rdata_o[2] == fast_avail_ni));

  a_r9_spare_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && port != BASE && port != BASE + 8'd1) |-> rdata_o == 8'hFF);

  a_r11_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> rdata_o == 8'h00);

  a_r11_read_only_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> rd_i);
endmodule

bind sio_bank_sel sio_bank_sel_chk #(.DEV_ID(DEV_ID), .BASE(BASE)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .rd_i(rd_i), .wr_i(wr_i), .fast_avail_ni(fast_avail_ni), .sw_off_i(sw_off_i),
  .rdata_o(rdata_o), .drive_o(drive_o), .speed_slow_o(speed_slow_o), .id_q(id_q)
);

// File: tb/test_sio_bank_sel.sv
module test_sio_bank_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        fa_n = 1'b0, sw_off = 1'b0;
  logic [7:0]  rdata_n, rdata_w;
  logic        drv_n, drv_w, spd_n, spd_w;
  int          checks = 0, fails = 0, cycles = 0;
  string       req = "R1";

  always #5 clk = ~clk;

  sio_bank_sel i_sio_bank_sel (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .fast_avail_ni(fa_n), .sw_off_i(sw_off), .rdata_o(rdata_n), .drive_o(drv_n),
    .speed_slow_o(spd_n));

  sio_bank_sel #(.WIDE_DECODE(1'b1), .HI_TAG(8'h12)) i_sio_bank_sel_wide (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .fast_avail_ni(fa_n), .sw_off_i(sw_off), .rdata_o(rdata_w), .drive_o(drv_w),
    .speed_slow_o(spd_w));

  // behavioural reference
  int m_id, m_spd_n, m_spd_w;

  function automatic bit in_window(int a, bit wide);
    if (wide && ((a >> 8) & 255) != 'h12) return 0;
    return ((a & 255) >= 'h41) && ((a & 255) <= 'h4F);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_id = 0; m_spd_n = 1; m_spd_w = 1;
    end else if (wr) begin
      if (m_id == 8 && (addr & 255) == 'h41) begin
        m_spd_n = wdata & 1;
        if (in_window(addr, 1)) m_spd_w = wdata & 1;
      end
      if ((addr & 255) == 'h40) m_id = wdata;
    end
  end

  function automatic int exp_data(bit wide, int spd, output bit drv);
    drv = 0;
    if (!rd || m_id != 8) return 0;
    if ((addr & 255) == 'h40) begin drv = 1; return (~m_id) & 255; end
    if (!in_window(addr, wide)) return 0;
    drv = 1;
    if ((addr & 255) == 'h41) return 'h7A | spd | (fa_n << 2) | (sw_off << 7);
    return 'hFF;
  endfunction

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit d; int e;
    e = exp_data(0, m_spd_n, d);
    cmp("narrow drive", drv_n, d);
    cmp("narrow rdata", rdata_n, e);
    cmp("narrow speed", spd_n, m_spd_n);
    e = exp_data(1, m_spd_w, d);
    cmp("wide drive", drv_w, d);
    cmp("wide rdata", rdata_w, e);
    cmp("wide speed", spd_w, m_spd_w);
  end

  task automatic io_wr(int a, int d);
    @(posedge clk); #1 addr = a[15:0]; wdata = d[7:0]; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic io_rd(int a);
    @(posedge clk); #1 addr = a[15:0]; rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  initial begin
    req = "R1"; repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    io_rd('h0040);
    req = "R4"; io_rd('h0041); io_rd('h004F);
    req = "R6"; io_wr('h0041, 0); io_wr('h1241, 0);
    req = "R2"; io_wr('h0040, 8);
    req = "R3"; io_rd('h0040);
    req = "R6"; io_rd('h0041);
    req = "R5"; io_wr('h0041, 0); io_rd('h0041); io_wr('h0041, 1); io_wr('h0041, 8'hFE);
    req = "R8"; io_wr('h0041, 8'h00); fa_n = 1'b1; io_rd('h0041);
    req = "R7"; sw_off = 1'b1; io_rd('h0041); fa_n = 1'b0; io_rd('h0041);
    req = "R9"; io_rd('h0042); io_rd('h004F); io_rd('h0050);
    req = "R10"; io_wr('h1241, 1); io_rd('h1241); io_rd('h1243); io_rd('h3441); io_rd('h3440);
    req = "R2"; io_wr('h1240, 200); io_rd('h0040);
    req = "R4"; io_rd('h0041); io_rd('h1241);
    req = "R6"; io_wr('h0041, 1); io_wr('h1241, 0);
    req = "R11"; io_wr('h0040, 8); io_rd('h0030);
    @(posedge clk); #1 addr = 'h0041; rd = 1'b0;
    io_rd('h0041);
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule